// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is an on-chip single-port synchronous memory. Every access has a fixed two-cycle data phase. The address and all control inputs are captured on a rising clock edge. The data for that command is exchanged exactly two edges later, whether the command is a read or a write. Because reads and writes share this one latency, a caller can issue any mix of them on consecutive cycles, and the data bus never needs an idle cycle to turn around. Each word is 36 bits wide and is split into four 9-bit lanes, and each lane has its own write enable.

Three chip selects qualify every new command, and an active-low clock enable stalls the whole block. A load/advance control either starts a new access or continues a four-beat burst. The burst order is chosen when the burst is loaded and can be linear or interleaved. The shared data bus is split into a write-data input and a read-data output. A read-valid flag marks good output data, and an asynchronous output enable gates that flag.

Top module: `zbt_sram`

## Requirements
- R1: A read command captured at edge k presents the addressed word on `rdata` with `rvalid` high after edge k+2, and `rvalid` is low after an edge whose data phase is not a read.
- R2: A write command captured at edge k takes its data from `wdata` at edge k+2, which is the write data phase.
- R3: Commands may be issued on consecutive cycles in any mix. A read returns the newest write to its address, including a write whose data phase fell on the cycle just before the read's data phase.
- R4: `lane_wr_n[i]` is active low and covers bits [9i+8:9i]. A write updates only the enabled lanes and leaves the other lanes of the word unchanged.
- R5: While `ce_n` is high, all synchronous inputs are ignored. The pipeline, the burst state, the memory and the outputs all keep their values.
- R6: A command is loaded only when `adv_ld` is low, `cs_a_n` is low, `cs_b` is high and `cs_c_n` is low. A load cycle with any chip select inactive is a deselect: it writes nothing and produces no `rvalid`.
- R7: With `adv_ld` high, the block continues the current burst. A burst has at most four beats, counting the loaded one, and any further advance cycle is a deselect.
- R8: Linear order (`order_ilv` = 0 at load): beat n uses address low bits (start + n) mod 4, and the upper address bits are kept.
- R9: Interleaved order (`order_ilv` = 1 at load): beat n uses address low bits start XOR n. The order is fixed at load time, and `order_ilv` has no effect during advance cycles.
- R10: Burst beats keep the read/write direction of the loading command, and `rd_wr_n` is ignored during advance cycles.
- R11: `oe_n` high forces `rvalid` low without delay and does not disturb the pipeline. Lowering `oe_n` reveals held read data at once.
- R12: An active-low `rst_n` clears all pending commands, the burst state and `rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Clock enable, active low; high stalls the block |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| rd_wr_n | input | 1 | 1 = read, 0 = write (sampled on load) |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| order_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | 8 | Word address |
| wdata | input | 36 | Write data for the current data phase |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 36 | Read data |
| rvalid | output | 1 | Read data valid (gated by oe_n) |

## Verification
A cycle-by-cycle table interleaves writes and reads back to back. It separates a correct two-cycle data phase from one that is off by a cycle, and it shows whether a partial-lane write merges into the old word or overwrites it. Burst reads from several start addresses in both orders show whether the low bits wrap or carry into the upper bits, and whether the order and the direction are held after load. Directed stalls, chip-select combinations, output-enable toggles and a mid-flight reset each tell a correct hold or discard apart from a command that leaks through.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  localparam int BURST_BEATS = 4;

  // Low two address bits of burst beat `beat` for a given start.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    logic [1:0] r;
    if (ilv) r = start ^ beat;
    else     r = start + beat;
    return r;
  endfunction

  function automatic logic chips_on(input logic a_n, input logic b,
                                    input logic c_n);
    return !a_n && b && !c_n;
  endfunction

endpackage

// File: rtl/zbt_cmd_ctrl.sv
module zbt_cmd_ctrl
  import zbt_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             adv_ld,
  input  logic             rd_wr_n,
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             cs_c_n,
  input  logic             order_ilv,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_wr_n,
  output logic             issue,
  output logic             issue_rd,
  output logic [AW-1:0]    issue_addr,
  output logic [LANES-1:0] issue_lane
);

  logic          bst_active;
  logic [1:0]    bst_beat;
  logic [1:0]    beat_nx;
  logic [AW-1:0] bst_base;
  logic          bst_rd;
  logic          bst_ilv;

  logic load_ok;
  logic cont_ok;
  logic last_beat;

  assign last_beat = (bst_beat == 2'(BURST_BEATS - 1));
  assign beat_nx   = bst_beat + 2'd1;
  assign load_ok   = !adv_ld && chips_on(cs_a_n, cs_b, cs_c_n);
  assign cont_ok   = adv_ld && bst_active && !last_beat;

  always_comb begin
    issue      = load_ok || cont_ok;
    issue_rd   = load_ok ? rd_wr_n : bst_rd;
    issue_lane = ~lane_wr_n;
    if (load_ok) issue_addr = addr;
    else         issue_addr = {bst_base[AW-1:2],
                               beat_low(bst_base[1:0], beat_nx, bst_ilv)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst_active <= 1'b0;
      bst_beat   <= 2'd0;
      bst_base   <= '0;
      bst_rd     <= 1'b0;
      bst_ilv    <= 1'b0;
    end else if (ce) begin
      if (!adv_ld) begin
        bst_active <= load_ok;
        bst_beat   <= 2'd0;
        bst_base   <= addr;
        bst_rd     <= rd_wr_n;
        bst_ilv    <= order_ilv;
      end else if (cont_ok) begin
        bst_beat   <= beat_nx;
      end else begin
        bst_active <= 1'b0;
      end
    end
  end

  // R6
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_ld && (cs_a_n || !cs_b || cs_c_n)) |-> !issue);

  // R7
  burst_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ld && bst_beat == 2'd3) |-> !issue);

endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe #(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             in_vld,
  input  logic             in_rd,
  input  logic [AW-1:0]    in_addr,
  input  logic [LANES-1:0] in_lane,
  output logic             out_vld,
  output logic             out_rd,
  output logic [AW-1:0]    out_addr,
  output logic [LANES-1:0] out_lane
);

  localparam int PW = 2 + AW + LANES;

  logic [PW-1:0] stg [LAT];

  generate
    for (genvar s = 0; s < LAT; s++) begin : g_stage
      logic [PW-1:0] nxt;
      if (s == 0) begin : g_head
        assign nxt = {in_vld, in_rd, in_addr, in_lane};
      end else begin : g_body
        assign nxt = stg[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  stg[s] <= '0;
        else if (ce) stg[s] <= nxt;
      end
    end
  endgenerate

  assign {out_vld, out_rd, out_addr, out_lane} = stg[LAT-1];

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(stg[0]) && $stable(stg[LAT-1])));

  // R1
  stage_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && in_vld) |=> stg[0][PW-1]);

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             op_vld,
  input  logic             op_rd,
  input  logic [AW-1:0]    op_addr,
  input  logic [LANES-1:0] op_lane,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rd_vld
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] old_word;
  logic [DW-1:0] wr_word;
  logic          wr_fire;
  logic          rd_fire;

  assign old_word = mem[op_addr];
  assign wr_fire  = ce && op_vld && !op_rd;
  assign rd_fire  = ce && op_vld && op_rd;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign wr_word[g*LANE_W +: LANE_W] =
        op_lane[g] ? wdata[g*LANE_W +: LANE_W] : old_word[g*LANE_W +: LANE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_fire) mem[op_addr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rd_vld <= 1'b0;
    end else if (ce) begin
      rd_vld <= rd_fire;
      if (rd_fire) rdata <= old_word;
    end
  end

  // R4
  lane_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (mem[$past(op_addr)] == $past(wr_word)));

  // R1
  read_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (rd_vld && rdata == $past(old_word)));

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             cs_c_n,
  input  logic             adv_ld,
  input  logic             rd_wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             order_ilv,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             oe_n,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);

  logic             ce;
  logic             cmd_vld, cmd_rd;
  logic [AW-1:0]    cmd_addr;
  logic [LANES-1:0] cmd_lane;
  logic             ph_vld, ph_rd;
  logic [AW-1:0]    ph_addr;
  logic [LANES-1:0] ph_lane;
  logic             rd_vld_q;

  assign ce = !ce_n;

  zbt_cmd_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce(ce), .adv_ld(adv_ld), .rd_wr_n(rd_wr_n),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n), .order_ilv(order_ilv),
    .addr(addr), .lane_wr_n(lane_wr_n),
    .issue(cmd_vld), .issue_rd(cmd_rd), .issue_addr(cmd_addr),
    .issue_lane(cmd_lane)
  );

  zbt_pipe #(.AW(AW), .LANES(LANES), .LAT(2)) u_pipe (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .in_vld(cmd_vld), .in_rd(cmd_rd), .in_addr(cmd_addr), .in_lane(cmd_lane),
    .out_vld(ph_vld), .out_rd(ph_rd), .out_addr(ph_addr), .out_lane(ph_lane)
  );

  zbt_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .op_vld(ph_vld), .op_rd(ph_rd), .op_addr(ph_addr), .op_lane(ph_lane),
    .wdata(wdata), .rdata(rdata), .rd_vld(rd_vld_q)
  );

  assign rvalid = rd_vld_q && !oe_n;

  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> !oe_n);

  // R5
  out_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> ($stable(rd_vld_q) && $stable(rdata)));

endmodule

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
module zbt_sram_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b0;
  logic        cs_a_n = 1'b1, cs_b = 1'b0, cs_c_n = 1'b1;
  logic        adv_ld = 1'b0, rd_wr_n = 1'b1, order_ilv = 1'b0, oe_n = 1'b0;
  logic [3:0]  lane_wr_n = 4'hF;
  logic [7:0]  addr = '0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        rvalid;

  int errs = 0;
  int total = 0;

  localparam logic [2:0] SEL = 3'b010;   // {cs_a_n, cs_b, cs_c_n}
  localparam logic [2:0] OFF = 3'b110;
  localparam logic [35:0] B0 = 36'h0AA55AA01, B1 = 36'h13C3C3C02,
                          B2 = 36'h255AA5503, B3 = 36'h3F00FF004;

  always #2.5 clk = ~clk;

  zbt_sram u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .cs_c_n(cs_c_n), .adv_ld(adv_ld), .rd_wr_n(rd_wr_n), .lane_wr_n(lane_wr_n),
    .order_ilv(order_ilv), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rvalid(rvalid)
  );

  typedef struct packed {
    logic        sel; logic rd; logic [7:0] a; logic [3:0] ln;
    logic [35:0] d; logic ev; logic [35:0] ed;
  } vec_t;

  // Row i drives the command of edge i plus write data for row i-2;
  // expected output after edge i belongs to row i-2.
  localparam vec_t VEC [10] = '{
    '{1'b1, 1'b0, 8'h10, 4'h0, 36'h0,         1'b0, 36'h0},
    '{1'b1, 1'b0, 8'h11, 4'h0, 36'h0,         1'b0, 36'h0},
    '{1'b1, 1'b1, 8'h10, 4'h0, 36'h123456789, 1'b0, 36'h0},
    '{1'b1, 1'b1, 8'h11, 4'h0, 36'h987654321, 1'b0, 36'h0},
    '{1'b1, 1'b0, 8'h10, 4'hA, 36'h0,         1'b1, 36'h123456789},
    '{1'b1, 1'b1, 8'h10, 4'h0, 36'h0,         1'b1, 36'h987654321},
    '{1'b0, 1'b1, 8'h00, 4'h0, 36'h0,         1'b0, 36'h0},
    '{1'b0, 1'b1, 8'h00, 4'h0, 36'h0,         1'b1, 36'h120016600},
    '{1'b0, 1'b1, 8'h00, 4'h0, 36'h0,         1'b0, 36'h0},
    '{1'b0, 1'b1, 8'h00, 4'h0, 36'h0,         1'b0, 36'h0}
  };

  task automatic chk(input logic ok, input string req,
                     input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic adv, input logic rd, input logic [2:0] cs,
                     input logic [7:0] a, input logic [3:0] ln,
                     input logic [35:0] d, input logic ilv);
    adv_ld = adv; rd_wr_n = rd; {cs_a_n, cs_b, cs_c_n} = cs;
    addr = a; lane_wr_n = ln; wdata = d; order_ilv = ilv;
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input logic [35:0] d);
    put(1'b0, 1'b1, OFF, 8'h00, 4'hF, d, 1'b0);
  endtask

  task automatic single_wr(input logic [2:0] cs, input logic [7:0] a,
                           input logic [35:0] d);
    put(1'b0, 1'b0, cs, a, 4'h0, 36'h0, 1'b0); tick;
    idle(36'h0); tick;
    idle(d); tick;
    idle(36'h0);
  endtask

  task automatic single_rd(input logic [7:0] a, input logic [35:0] e,
                           input string req);
    put(1'b0, 1'b1, SEL, a, 4'hF, 36'h0, 1'b0); tick;
    idle(36'h0); tick; tick;
    chk(rvalid === 1'b1, req, {35'h0, rvalid}, 36'h1);
    chk(rdata === e, req, rdata, e);
  endtask

  // Load a read burst, four advances (the last one is a fifth beat), then idle.
  // Advance cycles drive write direction and the other order: both ignored.
  task automatic rd_burst(input logic [7:0] a, input logic ilv,
                          input logic [35:0] e0, e1, e2, e3, input string req);
    logic [35:0] ex [4];
    ex[0] = e0; ex[1] = e1; ex[2] = e2; ex[3] = e3;
    for (int k = 0; k < 7; k++) begin
      if (k == 0)      put(1'b0, 1'b1, SEL, a, 4'hF, 36'h0, ilv);
      else if (k <= 4) put(1'b1, 1'b0, SEL, 8'hFF, 4'h0, 36'h0, !ilv);
      else             idle(36'h0);
      tick;
      if (k >= 2 && k <= 5) begin
        chk(rvalid === 1'b1, req, {35'h0, rvalid}, 36'h1);
        chk(rdata === ex[k-2], req, rdata, ex[k-2]);
      end else if (k == 6) begin
        chk(rvalid === 1'b0, "R7 fifth beat", {35'h0, rvalid}, 36'h0);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errs++; total++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    idle(36'h0);
    @(negedge clk); @(negedge clk);
    chk(rvalid === 1'b0, "R12 reset state", {35'h0, rvalid}, 36'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4: back-to-back table
    for (int i = 0; i < 10; i++) begin
      put(1'b0, VEC[i].rd, VEC[i].sel ? SEL : OFF, VEC[i].a, VEC[i].ln,
          VEC[i].d, 1'b0);
      tick;
      chk(rvalid === VEC[i].ev, "R1 R3 table valid", {35'h0, rvalid},
          {35'h0, VEC[i].ev});
      if (VEC[i].ev) chk(rdata === VEC[i].ed, "R2 R4 table data", rdata,
                         VEC[i].ed);
    end

    // R7 R10: linear write burst at 0x22, rd_wr_n high on advances
    put(1'b0, 1'b0, SEL, 8'h22, 4'h0, 36'h0, 1'b0); tick;
    put(1'b1, 1'b1, SEL, 8'h00, 4'h0, 36'h0, 1'b0); tick;
    put(1'b1, 1'b1, SEL, 8'h00, 4'h0, B0, 1'b0); tick;
    put(1'b1, 1'b1, SEL, 8'h00, 4'h0, B1, 1'b0); tick;
    put(1'b1, 1'b1, SEL, 8'h00, 4'h0, B2, 1'b0); tick;
    idle(B3); tick;
    idle(36'h0); tick;
    chk(rvalid === 1'b0, "R10 write burst no read", {35'h0, rvalid}, 36'h0);
    single_rd(8'h22, B0, "R8 beat0");
    single_rd(8'h20, B2, "R8 wrap beat2");
    single_rd(8'h21, B3, "R8 wrap beat3");

    // R8 R9 R10: read bursts
    rd_burst(8'h21, 1'b0, B3, B0, B1, B2, "R8 linear burst");
    rd_burst(8'h23, 1'b1, B1, B0, B3, B2, "R9 interleaved burst");
    rd_burst(8'h21, 1'b1, B3, B2, B1, B0, "R9 interleaved burst 1");

    // R5: stall with a pending read, junk write offered during stall
    put(1'b0, 1'b1, SEL, 8'h22, 4'hF, 36'h0, 1'b0); tick;
    ce_n = 1'b1;
    put(1'b0, 1'b0, SEL, 8'h22, 4'h0, 36'h0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      tick;
      chk(rvalid === 1'b0, "R5 stall pending", {35'h0, rvalid}, 36'h0);
    end
    ce_n = 1'b0; idle(36'h0); tick;
    chk(rvalid === 1'b0, "R5 one enabled edge", {35'h0, rvalid}, 36'h0);
    tick;
    chk(rvalid === 1'b1 && rdata === B0, "R5 resumed read", rdata, B0);
    ce_n = 1'b1;
    for (int k = 0; k < 2; k++) begin
      tick;
      chk(rvalid === 1'b1 && rdata === B0, "R5 output held", rdata, B0);
    end
    ce_n = 1'b0; tick;
    chk(rvalid === 1'b0, "R5 released", {35'h0, rvalid}, 36'h0);
    single_rd(8'h22, B0, "R5 stall write ignored");

    // R6: each inactive chip select blocks write and read
    single_wr(3'b110, 8'h22, 36'h0);
    single_wr(3'b000, 8'h22, 36'h0);
    single_wr(3'b011, 8'h22, 36'h0);
    single_rd(8'h22, B0, "R6 deselected writes");
    put(1'b0, 1'b1, 3'b000, 8'h22, 4'hF, 36'h0, 1'b0); tick;
    idle(36'h0); tick; tick;
    chk(rvalid === 1'b0, "R6 deselected read", {35'h0, rvalid}, 36'h0);

    // R11: output enable gates the flag only
    oe_n = 1'b1;
    put(1'b0, 1'b1, SEL, 8'h23, 4'hF, 36'h0, 1'b0); tick;
    idle(36'h0); tick; tick;
    chk(rvalid === 1'b0, "R11 oe high", {35'h0, rvalid}, 36'h0);
    oe_n = 1'b0; #1;
    chk(rvalid === 1'b1 && rdata === B1, "R11 oe low", rdata, B1);

    // R12: reset mid-flight discards pending read
    @(negedge clk);
    put(1'b0, 1'b1, SEL, 8'h22, 4'hF, 36'h0, 1'b0); tick;
    idle(36'h0);
    rst_n = 1'b0; #1;
    chk(rvalid === 1'b0, "R12 reset clears", {35'h0, rvalid}, 36'h0);
    @(negedge clk); rst_n = 1'b1;
    tick; tick;
    chk(rvalid === 1'b0, "R12 pending dropped", {35'h0, rvalid}, 36'h0);
    put(1'b1, 1'b1, SEL, 8'h00, 4'hF, 36'h0, 1'b0); tick;
    idle(36'h0); tick; tick;
    chk(rvalid === 1'b0, "R12 burst cleared", {35'h0, rvalid}, 36'h0);

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

endmodule